// File: doc/BRIEF.md
# Serial ADC Link Model

This block is a synthesizable digital model of the converter-side control logic of a three-wire serial analog-to-digital converter. A host drives a serial clock and an active-low convert strobe. The block returns each conversion result on one data line that it can release to high impedance. A parallel input port supplies the sample value in place of the analog converter. The strobe's falling edge latches that value and opens a frame. The block then counts serial-clock edges within the frame. The edge count at the moment the strobe rises back high selects the next action: continuous conversion, a return to idle, or a step down in power.

Both the serial clock and the strobe are asynchronous to the system clock. Each passes through a synchronizer and an edge detector, and the serial clock is only ever counted, never used as a clock. The sample inputs are quasi-static: they must hold steady from the strobe's falling edge until the synchronizer has caught up with it. The tri-state pin is modelled as a data bit `sdo` plus an enable `sdo_en`. `sdo_en` low means high impedance.

The frame has a fixed layout, MSB first. It opens with LEAD zeros. The data bits follow, MSB first, then the sub-bits, then one trailing zero. With the default parameters the frame is 16 bits long.

Top module: `sadc_link`

## Requirements
- R1: After reset, `sdo_en`=0, `pwr_mode`=00 (normal), `ref_on`=1, `first_conv`=1 and `tracking`=1.
- R2: A falling strobe drives `sdo_en`=1 and `sdo`=0 and clears `tracking`. It also latches `samp_data` and `samp_sub`; any change to those inputs after that point has no effect on the current frame.
- R3: After the k-th serial-clock rising edge of a frame, `sdo` shows frame bit k. Bits 1 to 3 are zero, bits 4 to 13 are `samp_data` from bit 9 down to bit 0, bits 14 and 15 are `samp_sub[1]` and `samp_sub[0]`, and bit 16 is zero.
- R4: `tracking` goes high on the 14th rising edge of the frame.
- R5: If the strobe rises when the edge count is 14 or 15, `sdo_en` stays 1 and the frame runs to its end. `pwr_mode` becomes 00.
- R6: If the strobe is still low at a falling edge after the 16th rising edge, `sdo_en` goes to 0 at the next serial-clock rising edge or the next strobe rise, whichever comes first. A strobe rise with the count at 16 also sets `pwr_mode` to 00.
- R7: If the strobe rises with the count in the range 3 to 13 while `pwr_mode`=00, then `sdo_en` goes to 0 and `pwr_mode` becomes 01 (partial). `ref_on` stays 1.
- R8: The same kind of short frame while `pwr_mode`=01 moves it to 10 (full), and `ref_on` becomes 0. A short frame while in 10 leaves it at 10.
- R9: A power-down mode is left, back to 00, only by a strobe rise with a count of at least 14. A rise with a lower count keeps the block in a power-down mode.
- R10: `first_conv` stays 1 until the first frame reaches its 16th rising edge. Frames that end early do not clear it.
- R11: If the strobe rises with a count of 0 to 2, `sdo_en` goes to 0 and `pwr_mode` does not change.
- R12: Serial-clock edges while no frame is open leave `sdo_en` at 0 and `pwr_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host (asynchronous) |
| conv_strobe | input | 1 | Active-low convert strobe (asynchronous) |
| samp_data | input | DATA_W | Sample value standing in for the converter |
| samp_sub | input | SUB_W | Sub-bits sent after the data |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Output enable; 0 means high impedance |
| pwr_mode | output | 2 | 00 normal, 01 partial down, 10 full down |
| ref_on | output | 1 | Reference enabled (all modes except full down) |
| first_conv | output | 1 | Conversions before the first complete frame are invalid |
| tracking | output | 1 | Input stage is tracking (1) or holding (0) |

## Verification
The bench builds the block with its default parameters: ten data bits, two sub-bits, three leading zeros and two synchronizer stages. These values put the decision boundaries at edge counts 3, 14 and 16, the values the requirements name. The bench drives the serial clock at six system clocks per phase, which leaves room for the synchronizer delay before each sample point. Every strobe-rise position from edge 1 to edge 18 can then be reached. Random frame lengths also exercise the hold-low ending, and directed sequences walk the power modes down and back up.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    PWR_ON   = 2'b00,
    PWR_PART = 2'b01,
    PWR_OFF  = 2'b10
  } pwr_e;

  // one step deeper into power-down on a short frame
  function automatic pwr_e sleep_step(input pwr_e cur);
    return (cur == PWR_ON) ? PWR_PART : PWR_OFF;
  endfunction
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift #(
  parameter int FRAME_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  input  logic [FRAME_LEN-1:0] word,
  output logic                 q
);
  logic [FRAME_LEN-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      q  <= 1'b0;
    end else if (load) begin
      sr <= word;
      q  <= 1'b0;
    end else if (shift) begin
      q  <= sr[FRAME_LEN-1];
      sr <= {sr[FRAME_LEN-2:0], 1'b0};
    end
  end

  a_r3_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !q);
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
  import sadc_pkg::*;
#(
  parameter int LEAD_W = 3,
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2,
  parameter int TAIL_W = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic sclk_fall,
  input  logic cnv_fall,
  input  logic cnv_rise,
  output logic load,
  output logic shift,
  output logic oe,
  output pwr_e pwr,
  output logic init_pend,
  output logic trk
);
  localparam int FRAME_LEN = LEAD_W + DATA_W + SUB_W + TAIL_W;
  localparam int TRACK_AT  = LEAD_W + DATA_W + 1;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] K_LEAD  = CNT_W'(LEAD_W);
  localparam logic [CNT_W-1:0] K_TRACK = CNT_W'(TRACK_AT);
  localparam logic [CNT_W-1:0] K_FRAME = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic active, armed, cnv_low;

  assign cnt_nx = cnt + 1'b1;
  assign load   = cnv_fall;
  assign shift  = sclk_rise && active && !armed && !cnv_fall && !cnv_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      active    <= 1'b0;
      armed     <= 1'b0;
      cnv_low   <= 1'b0;
      oe        <= 1'b0;
      pwr       <= PWR_ON;
      init_pend <= 1'b1;
      trk       <= 1'b1;
    end else if (cnv_fall) begin
      cnt     <= '0;
      active  <= 1'b1;
      armed   <= 1'b0;
      cnv_low <= 1'b1;
      oe      <= 1'b1;
      trk     <= 1'b0;
    end else if (cnv_rise) begin
      cnv_low <= 1'b0;
      if (cnt < K_TRACK) begin
        // aborted or short frame: release the line, back to tracking
        oe     <= 1'b0;
        active <= 1'b0;
        trk    <= 1'b1;
        if (cnt >= K_LEAD) pwr <= sleep_step(pwr);
      end else if (cnt < K_FRAME) begin
        pwr <= PWR_ON;      // continuous: line stays driven
      end else begin
        pwr    <= PWR_ON;
        oe     <= 1'b0;
        active <= 1'b0;
        armed  <= 1'b0;
      end
    end else if (sclk_rise) begin
      if (armed) begin
        oe     <= 1'b0;
        active <= 1'b0;
        armed  <= 1'b0;
      end else if (active) begin
        if (cnt != K_FRAME) cnt <= cnt_nx;
        if (cnt_nx == K_TRACK) trk <= 1'b1;
        if (cnt_nx == K_FRAME) init_pend <= 1'b0;
      end
    end else if (sclk_fall) begin
      if (active && cnv_low && cnt == K_FRAME) armed <= 1'b1;
    end
  end

  a_r2_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_fall |=> (oe && !trk && active));
  a_r6_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> $past(cnv_rise || sclk_rise));
  a_r8_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr == PWR_ON) |=> (pwr != PWR_OFF));
  a_r9_mode_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr) |-> $past(cnv_rise));
  a_r10_init_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_pend) |-> $past(sclk_rise));
  a_r4_hold_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trk) |-> $past(cnv_fall));
endmodule

// File: rtl/sadc_link.sv
module sadc_link
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int LEAD_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              conv_strobe,
  input  logic [DATA_W-1:0] samp_data,
  input  logic [SUB_W-1:0]  samp_sub,
  output logic              sdo,
  output logic              sdo_en,
  output logic [1:0]        pwr_mode,
  output logic              ref_on,
  output logic              first_conv,
  output logic              tracking
);
  localparam int TAIL_W    = 1;
  localparam int FRAME_LEN = LEAD_W + DATA_W + SUB_W + TAIL_W;

  logic sclk_rise, sclk_fall, cnv_rise, cnv_fall;
  logic load, shift;
  pwr_e pwr;
  logic [FRAME_LEN-1:0] word;

  sadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk_in), .rise(sclk_rise), .fall(sclk_fall));

  sadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cnv_sync (
    .clk(clk), .rst_n(rst_n), .din(conv_strobe), .rise(cnv_rise), .fall(cnv_fall));

  sadc_frame_ctrl #(.LEAD_W(LEAD_W), .DATA_W(DATA_W), .SUB_W(SUB_W), .TAIL_W(TAIL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cnv_fall(cnv_fall), .cnv_rise(cnv_rise),
    .load(load), .shift(shift), .oe(sdo_en), .pwr(pwr),
    .init_pend(first_conv), .trk(tracking));

  assign word = {{LEAD_W{1'b0}}, samp_data, samp_sub, {TAIL_W{1'b0}}};

  sadc_out_shift #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .word(word), .q(sdo));

  assign pwr_mode = pwr;
  assign ref_on   = (pwr != PWR_OFF);
endmodule

// File: tb/sadc_link_tb_top.sv
module sadc_link_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk_in = 1'b0, conv_strobe = 1'b1;
  logic [9:0] samp_data = '0;
  logic [1:0] samp_sub = '0;
  logic sdo, sdo_en, ref_on, first_conv, tracking;
  logic [1:0] pwr_mode;

  always #(CLK_P/2) clk = ~clk;

  sadc_link dut_i (.clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .conv_strobe(conv_strobe),
    .samp_data(samp_data), .samp_sub(samp_sub), .sdo(sdo), .sdo_en(sdo_en),
    .pwr_mode(pwr_mode), .ref_on(ref_on), .first_conv(first_conv), .tracking(tracking));

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  bit e_active = 0, e_armed = 0, e_low = 0, e_en = 0, e_init = 1, e_trk = 1, e_dout = 0;
  int e_cnt = 0;
  logic [1:0] e_pwr = 2'b00;
  logic [15:0] e_word = '0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] step_down(logic [1:0] p);
    return (p == 2'b00) ? 2'b01 : 2'b10;
  endfunction

  function automatic bit frame_bit(logic [15:0] w, int k);
    return (k >= 1 && k <= 16) ? w[16-k] : 1'b0;
  endfunction

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic strobe_fall(logic [9:0] d, logic [1:0] s);
    samp_data = d; samp_sub = s;
    conv_strobe = 1'b0;
    wait_half();
    samp_data = ~d; samp_sub = ~s;   // R2: later changes must not reach the frame
    e_active = 1; e_armed = 0; e_low = 1; e_cnt = 0; e_en = 1; e_trk = 0; e_dout = 0;
    e_word = {3'b000, d, s, 1'b0};
    chk("R2 sdo_en", sdo_en, 1);
    chk("R2 sdo", sdo, 0);
    chk("R2 tracking", tracking, 0);
  endtask

  task automatic sclk_rise_step();
    string tag;
    sclk_in = 1'b1;
    wait_half();
    tag = "R3";
    if (e_armed) begin
      e_en = 0; e_active = 0; e_armed = 0; tag = "R6";
    end else if (e_active) begin
      if (e_cnt < 16) e_cnt++;
      if (e_cnt == 14) e_trk = 1;
      if (e_cnt == 16) e_init = 0;
      e_dout = frame_bit(e_word, e_cnt);
    end else tag = "R12";
    chk({tag, " sdo_en"}, sdo_en, e_en);
    if (e_en && e_active) chk("R3 sdo", sdo, e_dout);
    chk("R4 tracking", tracking, e_trk);
    chk("R10 first_conv", first_conv, e_init);
    if (tag == "R12") chk("R12 pwr_mode", pwr_mode, e_pwr);
  endtask

  task automatic sclk_fall_step();
    sclk_in = 1'b0;
    wait_half();
    if (e_active && e_low && e_cnt == 16) e_armed = 1;
  endtask

  task automatic strobe_rise();
    string tag;
    conv_strobe = 1'b1;
    wait_half();
    e_low = 0;
    if (e_cnt < 3) begin
      e_en = 0; e_active = 0; e_trk = 1; tag = "R11";
    end else if (e_cnt < 14) begin
      e_en = 0; e_active = 0; e_trk = 1;
      tag = (e_pwr == 2'b00) ? "R7" : "R8";
      e_pwr = step_down(e_pwr);
    end else if (e_cnt < 16) begin
      tag = (e_pwr == 2'b00) ? "R5" : "R9";
      e_pwr = 2'b00;
    end else begin
      e_en = 0; e_active = 0; e_armed = 0; e_pwr = 2'b00; tag = "R6";
    end
    chk({tag, " sdo_en"}, sdo_en, e_en);
    chk({tag, " pwr_mode"}, pwr_mode, e_pwr);
    chk({tag, " ref_on"}, ref_on, (e_pwr != 2'b10));
    chk("R4 tracking", tracking, e_trk);
  endtask

  // cr_at = 0: strobe held low through all edges, raised afterwards
  task automatic run_frame(logic [9:0] d, logic [1:0] s, int n, int cr_at);
    strobe_fall(d, s);
    for (int k = 1; k <= n; k++) begin
      sclk_rise_step();
      sclk_fall_step();
      if (k == cr_at) strobe_rise();
    end
    if (conv_strobe == 1'b0) strobe_rise();
  endtask

  task automatic idle_clocks(int n);
    for (int k = 0; k < n; k++) begin
      sclk_rise_step();
      sclk_fall_step();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sdo_en", sdo_en, 0);
    chk("R1 pwr_mode", pwr_mode, 0);
    chk("R1 ref_on", ref_on, 1);
    chk("R1 first_conv", first_conv, 1);
    chk("R1 tracking", tracking, 1);
    // R12 idle clocks before any frame
    idle_clocks(3);
    // R11 abort at count 2, R10 flag not cleared
    run_frame(10'h2A5, 2'b10, 16, 2);
    // R7 short frame -> partial, R9 wake by count 16 (R6 end)
    run_frame(10'h3FF, 2'b11, 16, 5);
    run_frame(10'h155, 2'b01, 16, 16);
    // R10 cleared by complete frame; R5 continuous run
    run_frame(10'h200, 2'b10, 16, 14);
    run_frame(10'h001, 2'b01, 16, 15);
    // R8 partial -> full, full stays full, R9 short frame no wake
    run_frame(10'h0F0, 2'b00, 16, 3);
    run_frame(10'h0F0, 2'b00, 16, 13);
    idle_clocks(2);
    run_frame(10'h333, 2'b11, 16, 10);
    run_frame(10'h0AA, 2'b10, 16, 1);
    // R6 strobe held low past frame end, released by clock edge; wake R9
    run_frame(10'h2CC, 2'b01, 18, 0);
    // random frames
    for (int i = 0; i < 150; i++) begin
      int n, cr;
      n  = 16 + $urandom_range(0, 2);
      cr = $urandom_range(0, n);
      run_frame(10'($urandom), 2'($urandom), n, cr);
      if ($urandom_range(0, 3) == 0) idle_clocks($urandom_range(1, 3));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule